// File: doc/BRIEF.md
# Ethernet Single-Frame Transmit Buffer

This block sits between a processor-side register interface and a MAC transmitter. Software loads one outgoing frame as a sequence of 32-bit words, then raises a request strobe. The block checks the length carried in the first word and, if the length is acceptable, presents the frame one byte per beat on a valid/ready stream. It can stretch short frames with zero bytes to the Ethernet minimum, and it tells the downstream stage whether a frame check sequence should be appended.

The buffer holds exactly one frame. From the request until the last byte is accepted, the block reads as busy, and it refuses further words and further requests. At the end, the write pointer returns to the first word, so the next frame can be loaded from scratch. A completion flag and an error flag stay set until software clears them.

Top module: `ethtx_frame_buf`

## Requirements
- R1: After reset, `busy`, `tx_valid`, `fcs_append`, `irq_tx_done` and `irq_tx_err` are all 0.
- R2: A `req_set` pulse while idle makes `busy` read 1 from the next cycle onward. `busy` stays 1 until the final byte is accepted and reads 0 in the cycle after that handshake. `tx_valid` is never 1 while `busy` is 0.
- R3: Word 0 carries the payload length P in bits [15:0], destination byte 1 in bits [23:16] and destination byte 2 in bits [31:24]. Each later word carries the next four frame bytes, the earliest in bits [7:0]. The stream carries exactly P+14 bytes in frame order.
- R4: `tx_last` is 1 only on the final byte. While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_last` hold.
- R5: When the pad option is captured as 1 at request time and P+14 is below MIN_FRAME_BYTES (60 by default), zero bytes follow the frame until MIN_FRAME_BYTES bytes have been sent. With the pad option at 0, or with longer frames, no bytes are added.
- R6: If P exceeds MAX_FRAME_BYTES-14 (2032 by default), no byte is sent. `busy` reads 1 for exactly one cycle and `irq_tx_err` is then set.
- R7: A request made with no word written since the last frame ended sets `irq_tx_err` and sends nothing.
- R8: `irq_tx_done` is set in the cycle after the final byte is accepted. Both flags stay set until their clear input is pulsed. When a set and a clear of the same flag fall in the same cycle, the set wins.
- R9: Data words and `req_set` pulses that arrive while `busy` is 1 have no effect on the frame in flight. They also do not start another transmission.
- R10: Once a frame completes or fails, the next word written is taken as word 0 of a new frame.
- R11: `fcs_append` equals the CRC option captured at request time while `tx_valid` is 1, and reads 0 otherwise.
- R12: Words written beyond the buffer capacity are discarded. They do not overwrite stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Data-register write strobe |
| wr_data | input | 32 | Word written to the buffer |
| req_set | input | 1 | Pulse that requests transmission |
| cfg_pad_en | input | 1 | Pad short frames to the minimum size |
| cfg_crc_en | input | 1 | Ask the MAC to append the FCS |
| clr_tx_done | input | 1 | Clears the completion flag |
| clr_tx_err | input | 1 | Clears the error flag |
| busy | output | 1 | Request bit read-back; 1 while a frame is pending |
| tx_valid | output | 1 | Byte stream valid |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Marks the final byte of the frame, padding included |
| tx_ready | input | 1 | Byte stream ready from the MAC |
| fcs_append | output | 1 | FCS append request for the frame in flight |
| irq_tx_done | output | 1 | Sticky transmit-complete flag |
| irq_tx_err | output | 1 | Sticky transmit-error flag |

## Verification
Two pairs of actions can fall in the same cycle, and the bench provokes both.

The first pair is completion and a flag clear. The bench pulses `clr_tx_done` in the same cycle that the final byte is accepted. It then expects `irq_tx_done` to read 1, because the set must win.

The second pair is a busy frame and software activity. In the middle of a frame, the bench drives a data word and a request together. It expects the byte stream to match the computed frame exactly, and it expects `busy` to stay 0 afterwards.

Every payload length of a small buffer configuration is swept with alternating pad and CRC options and irregular ready stalls. The expected bytes and the padded length are computed arithmetically from the payload length.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;
   // width of the length field at the bottom of word 0
   localparam int LEN_W     = 16;
   // byte counter wide enough for any header length plus the address/type bytes
   localparam int CNT_W     = LEN_W + 1;
   // destination + source + type bytes not counted in the header length
   localparam int HDR_BYTES = 14;
   // bytes of word 0 taken by the length field
   localparam int LEN_LANES = 2;
   localparam int LANES     = 4;

   typedef enum logic [1:0] {
      TXS_IDLE  = 2'd0,
      TXS_CHECK = 2'd1,
      TXS_SEND  = 2'd2
   } txs_e;

   typedef logic [CNT_W-1:0] bcnt_t;
endpackage

// File: rtl/ethtx_word_store.sv
module ethtx_word_store
   import ethtx_pkg::*;
#(
   parameter int DEPTH_WORDS = 512,
   parameter int BYTE_AW     = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [31:0]        wr_data,
   input  logic               lock,
   input  logic               ptr_clr,
   input  logic [BYTE_AW-1:0] rd_addr,
   output logic [7:0]         rd_byte,
   output logic [LEN_W-1:0]   hdr_len,
   output logic               hdr_seen
);
   localparam int WAW   = BYTE_AW - 2;
   localparam int PTR_W = WAW + 1;

   logic [31:0]      mem [DEPTH_WORDS];
   logic [PTR_W-1:0] wr_ptr;
   logic             accept;
   logic [31:0]      rd_word;
   logic [7:0]       lane_byte [LANES];

   // words are refused while a frame is pending or once the buffer is full
   assign accept = wr_en && !lock && (wr_ptr < PTR_W'(DEPTH_WORDS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wr_ptr <= '0;
      else if (ptr_clr) wr_ptr <= '0;
      else if (accept)  wr_ptr <= wr_ptr + PTR_W'(1);
   end

   // the length field is kept in its own register so the check needs no memory read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          hdr_len <= '0;
      else if (accept && (wr_ptr == '0))   hdr_len <= wr_data[LEN_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr[WAW-1:0]] <= wr_data;
   end

   assign hdr_seen = (wr_ptr != '0);

   assign rd_word = mem[rd_addr[BYTE_AW-1:2]];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_byte[g] = rd_word[8*g +: 8];
   end

   assign rd_byte = lane_byte[rd_addr[1:0]];
endmodule

// File: rtl/ethtx_ctrl.sv
module ethtx_ctrl
   import ethtx_pkg::*;
#(
   parameter int MAX_PAYLOAD = 2032
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_set,
   input  logic             hdr_seen,
   input  logic [LEN_W-1:0] hdr_len,
   input  logic             cfg_pad,
   input  logic             cfg_crc,
   input  logic             last_beat,
   input  logic             clr_done,
   input  logic             clr_err,
   output logic             busy,
   output logic             sending,
   output logic             pad_q,
   output logic             crc_q,
   output logic             ptr_clr,
   output logic             flag_done,
   output logic             flag_err
);
   txs_e state;
   logic hdr_bad;
   logic fail_now;
   logic finish_now;

   assign hdr_bad    = !hdr_seen || (hdr_len > LEN_W'(MAX_PAYLOAD));
   assign fail_now   = (state == TXS_CHECK) && hdr_bad;
   assign finish_now = (state == TXS_SEND) && last_beat;
   assign ptr_clr    = fail_now || finish_now;
   assign busy       = (state != TXS_IDLE);
   assign sending    = (state == TXS_SEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TXS_IDLE;
         pad_q <= 1'b0;
         crc_q <= 1'b0;
      end else begin
         unique case (state)
            TXS_IDLE: if (req_set) begin
               state <= TXS_CHECK;
               pad_q <= cfg_pad;
               crc_q <= cfg_crc;
            end
            TXS_CHECK: state <= hdr_bad ? TXS_IDLE : TXS_SEND;
            TXS_SEND:  if (last_beat) state <= TXS_IDLE;
            default:   state <= TXS_IDLE;
         endcase
      end
   end

   // a set and a clear of the same flag in one cycle leave the flag set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_done <= 1'b0;
         flag_err  <= 1'b0;
      end else begin
         if (finish_now)    flag_done <= 1'b1;
         else if (clr_done) flag_done <= 1'b0;
         if (fail_now)      flag_err  <= 1'b1;
         else if (clr_err)  flag_err  <= 1'b0;
      end
   end
endmodule

// File: rtl/ethtx_unpack.sv
module ethtx_unpack
   import ethtx_pkg::*;
#(
   parameter int MIN_FRAME   = 60,
   parameter bit PAD_SUPPORT = 1'b1,
   parameter int BYTE_AW     = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sending,
   input  logic               pad_q,
   input  logic               tx_ready,
   input  logic [LEN_W-1:0]   hdr_len,
   input  logic [7:0]         rd_byte,
   output logic [BYTE_AW-1:0] rd_addr,
   output logic               tx_valid,
   output logic [7:0]         tx_data,
   output logic               tx_last
);
   bcnt_t byte_cnt;
   bcnt_t frame_len;
   bcnt_t send_len;
   logic  in_frame;

   assign frame_len = {1'b0, hdr_len} + CNT_W'(HDR_BYTES);

   if (PAD_SUPPORT) begin : g_pad
      assign send_len = (pad_q && (frame_len < CNT_W'(MIN_FRAME))) ?
                        CNT_W'(MIN_FRAME) : frame_len;
   end else begin : g_nopad
      logic unused_pad;
      assign unused_pad = pad_q;
      assign send_len   = frame_len;
   end

   // frame byte k lives at buffer byte k+2: word 0 opens with the length field
   assign rd_addr  = BYTE_AW'(byte_cnt + CNT_W'(LEN_LANES));
   assign in_frame = (byte_cnt < frame_len);
   assign tx_valid = sending;
   assign tx_data  = in_frame ? rd_byte : 8'h00;
   assign tx_last  = sending && (byte_cnt == (send_len - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         byte_cnt <= '0;
      else if (!sending)  byte_cnt <= '0;
      else if (tx_ready)  byte_cnt <= byte_cnt + CNT_W'(1);
   end
endmodule

// File: rtl/ethtx_frame_buf.sv
module ethtx_frame_buf
   import ethtx_pkg::*;
#(
   parameter int MAX_FRAME_BYTES = 2046,
   parameter int MIN_FRAME_BYTES = 60,
   parameter bit PAD_SUPPORT     = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   input  logic        req_set,
   input  logic        cfg_pad_en,
   input  logic        cfg_crc_en,
   input  logic        clr_tx_done,
   input  logic        clr_tx_err,
   output logic        busy,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        tx_last,
   input  logic        tx_ready,
   output logic        fcs_append,
   output logic        irq_tx_done,
   output logic        irq_tx_err
);
   localparam int MAX_PAYLOAD = MAX_FRAME_BYTES - HDR_BYTES;
   localparam int BUF_BYTES   = MAX_FRAME_BYTES + LEN_LANES;
   localparam int DEPTH_WORDS = 2 ** $clog2((BUF_BYTES + LANES - 1) / LANES);
   localparam int BYTE_AW     = $clog2(DEPTH_WORDS) + 2;

   if (MAX_FRAME_BYTES < HDR_BYTES + 2) begin : g_bad_max
      $error("MAX_FRAME_BYTES too small for an address/type header");
   end
   if (MAX_PAYLOAD >= (1 << LEN_W)) begin : g_bad_len
      $error("MAX_FRAME_BYTES exceeds the length field range");
   end
   if (MIN_FRAME_BYTES > MAX_FRAME_BYTES || MIN_FRAME_BYTES < 1) begin : g_bad_min
      $error("MIN_FRAME_BYTES must lie in 1..MAX_FRAME_BYTES");
   end

   logic               sending;
   logic               pad_q;
   logic               crc_q;
   logic               ptr_clr;
   logic               hdr_seen;
   logic [LEN_W-1:0]   hdr_len;
   logic [BYTE_AW-1:0] rd_addr;
   logic [7:0]         rd_byte;
   logic               last_beat;

   assign last_beat  = tx_valid && tx_ready && tx_last;
   assign fcs_append = tx_valid && crc_q;

   ethtx_word_store #(
      .DEPTH_WORDS (DEPTH_WORDS),
      .BYTE_AW     (BYTE_AW)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .lock     (busy),
      .ptr_clr  (ptr_clr),
      .rd_addr  (rd_addr),
      .rd_byte  (rd_byte),
      .hdr_len  (hdr_len),
      .hdr_seen (hdr_seen)
   );

   ethtx_ctrl #(
      .MAX_PAYLOAD (MAX_PAYLOAD)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_set   (req_set),
      .hdr_seen  (hdr_seen),
      .hdr_len   (hdr_len),
      .cfg_pad   (cfg_pad_en),
      .cfg_crc   (cfg_crc_en),
      .last_beat (last_beat),
      .clr_done  (clr_tx_done),
      .clr_err   (clr_tx_err),
      .busy      (busy),
      .sending   (sending),
      .pad_q     (pad_q),
      .crc_q     (crc_q),
      .ptr_clr   (ptr_clr),
      .flag_done (irq_tx_done),
      .flag_err  (irq_tx_err)
   );

   ethtx_unpack #(
      .MIN_FRAME   (MIN_FRAME_BYTES),
      .PAD_SUPPORT (PAD_SUPPORT),
      .BYTE_AW     (BYTE_AW)
   ) u_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .sending  (sending),
      .pad_q    (pad_q),
      .tx_ready (tx_ready),
      .hdr_len  (hdr_len),
      .rd_byte  (rd_byte),
      .rd_addr  (rd_addr),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_last  (tx_last)
   );
endmodule

// File: rtl/ethtx_frame_buf_chk.sv
module ethtx_frame_buf_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_set,
   input logic       busy,
   input logic       tx_valid,
   input logic [7:0] tx_data,
   input logic       tx_last,
   input logic       tx_ready,
   input logic       fcs_append,
   input logic       irq_tx_done,
   input logic       irq_tx_err
);
   p_valid_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> busy);

   p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_set));

   p_end_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> !busy);

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   p_err_nosend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_tx_err) |-> ($past(busy) && !$past(tx_valid)));

   p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_tx_done) |-> $past(tx_valid && tx_ready && tx_last));

   p_fcs_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |-> !fcs_append);
endmodule

bind ethtx_frame_buf ethtx_frame_buf_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_set     (req_set),
   .busy        (busy),
   .tx_valid    (tx_valid),
   .tx_data     (tx_data),
   .tx_last     (tx_last),
   .tx_ready    (tx_ready),
   .fcs_append  (fcs_append),
   .irq_tx_done (irq_tx_done),
   .irq_tx_err  (irq_tx_err)
);

// File: tb/test_ethtx_frame_buf.sv
module test_ethtx_frame_buf;
   localparam int MAXF = 126;
   localparam int MINF = 60;
   localparam int MAXP = MAXF - 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        req_set = 1'b0;
   logic        cfg_pad_en = 1'b0;
   logic        cfg_crc_en = 1'b0;
   logic        clr_tx_done = 1'b0;
   logic        clr_tx_err = 1'b0;
   logic        tx_ready = 1'b0;
   logic        busy, tx_valid, tx_last, fcs_append, irq_tx_done, irq_tx_err;
   logic [7:0]  tx_data;

   int nchk = 0;
   int nfail = 0;
   int wd = 0;
   bit ended = 1'b0;

   always #2 clk = ~clk;

   ethtx_frame_buf #(
      .MAX_FRAME_BYTES (MAXF),
      .MIN_FRAME_BYTES (MINF),
      .PAD_SUPPORT     (1'b1)
   ) i_ethtx_frame_buf (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
      .req_set (req_set), .cfg_pad_en (cfg_pad_en), .cfg_crc_en (cfg_crc_en),
      .clr_tx_done (clr_tx_done), .clr_tx_err (clr_tx_err), .busy (busy),
      .tx_valid (tx_valid), .tx_data (tx_data), .tx_last (tx_last),
      .tx_ready (tx_ready), .fcs_append (fcs_append),
      .irq_tx_done (irq_tx_done), .irq_tx_err (irq_tx_err)
   );

   task automatic summary();
      ended = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !ended) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", wd);
         summary();
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] bval(input int p, input int k);
      return 8'((k * 7 + p * 3 + 1) & 255);
   endfunction

   // word layout from R3: length low, then frame bytes from lane 2 onward
   function automatic logic [31:0] mk_word(input int p, input int i);
      logic [31:0] w;
      int          len;
      len = p + 14;
      if (i == 0) return {bval(p, 1), bval(p, 0), 16'(p)};
      w = '0;
      for (int j = 0; j < 4; j++) begin
         if (4 * i + j - 2 < len) w[8*j +: 8] = bval(p, 4 * i + j - 2);
      end
      return w;
   endfunction

   task automatic put_word(input logic [31:0] w);
      wr_en = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_frame(input int p, input bit pad, input bit crc, input int seed,
                            input bit race, input bit meddle, input bit extra,
                            input string tag);
      int len, nw, exp_n, idx, cyc;
      bit bad, rdy;
      logic [7:0] exp_b;
      longint act_v, exp_v;
      len = p + 14;
      nw = (len + 5) / 4;
      exp_n = (pad && len < MINF) ? MINF : len;
      for (int i = 0; i < nw; i++) put_word(mk_word(p, i));
      if (extra) put_word(32'h0000_0005);
      cfg_pad_en = pad;
      cfg_crc_en = crc;
      req_set = 1'b1;
      @(negedge clk);
      req_set = 1'b0;
      check(busy === 1'b1 && tx_valid === 1'b0, "R2", "busy after request", busy, 1);
      idx = 0; cyc = 0; bad = 1'b0; act_v = 0; exp_v = 0;
      while (idx < exp_n && cyc < 4000) begin
         rdy = ((cyc * 5 + seed) % 7) != 0;
         tx_ready = rdy;
         if (meddle && cyc == 4) begin
            wr_en = 1'b1;
            wr_data = 32'hFFFF_FFFF;
            req_set = 1'b1;
         end
         if (tx_valid && rdy) begin
            exp_b = (idx < len) ? bval(p, idx) : 8'h00;
            if (!bad && (tx_data !== exp_b || tx_last !== (idx == exp_n - 1) ||
                         fcs_append !== crc)) begin
               bad = 1'b1;
               act_v = {idx[15:0], tx_last, fcs_append, tx_data};
               exp_v = {idx[15:0], (idx == exp_n - 1), crc, exp_b};
            end
            if (race && idx == exp_n - 1) clr_tx_done = 1'b1;
            idx++;
         end
         @(negedge clk);
         wr_en = 1'b0;
         req_set = 1'b0;
         clr_tx_done = 1'b0;
         cyc++;
      end
      tx_ready = 1'b0;
      check(!bad, tag, "byte/last/fcs content", act_v, exp_v);
      check(idx == exp_n, tag, "byte count", idx, exp_n);
      check(busy === 1'b0 && tx_valid === 1'b0 && irq_tx_done === 1'b1, "R2 R8",
            "idle with done flag after last byte", {busy, tx_valid, irq_tx_done}, 3'b001);
      if (meddle) begin
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(busy === 1'b0 && tx_valid === 1'b0, "R9", "no second transmission",
                  {busy, tx_valid}, 0);
         end
      end
      @(negedge clk);
      check(irq_tx_done === 1'b1, "R8", "done flag sticky", irq_tx_done, 1);
      clr_tx_done = 1'b1;
      @(negedge clk);
      clr_tx_done = 1'b0;
      check(irq_tx_done === 1'b0, "R8", "done flag cleared", irq_tx_done, 0);
   endtask

   task automatic run_bad(input int hdr, input int nwords, input string tag);
      for (int i = 0; i < nwords; i++)
         put_word((i == 0) ? {16'hA5A5, 16'(hdr)} : 32'h1234_5678);
      req_set = 1'b1;
      @(negedge clk);
      req_set = 1'b0;
      check(busy === 1'b1 && tx_valid === 1'b0, tag, "busy during length check",
            {busy, tx_valid}, 2'b10);
      @(negedge clk);
      check(busy === 1'b0 && tx_valid === 1'b0 && irq_tx_err === 1'b1, tag,
            "error flag, nothing sent", {busy, tx_valid, irq_tx_err}, 3'b001);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(tx_valid === 1'b0 && irq_tx_err === 1'b1, tag, "stays silent, flag sticky",
               {tx_valid, irq_tx_err}, 2'b01);
      end
      clr_tx_err = 1'b1;
      @(negedge clk);
      clr_tx_err = 1'b0;
      check(irq_tx_err === 1'b0, "R8", "error flag cleared", irq_tx_err, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(busy === 1'b0 && tx_valid === 1'b0 && fcs_append === 1'b0 &&
            irq_tx_done === 1'b0 && irq_tx_err === 1'b0, "R1", "reset state",
            {busy, tx_valid, fcs_append, irq_tx_done, irq_tx_err}, 0);

      // R7: request with an empty buffer
      run_bad(0, 0, "R7");
      // R10: first frame after the failure must begin at word 0
      run_frame(3, 1'b0, 1'b1, 1, 1'b0, 1'b0, 1'b0, "R10");

      // R3 R5 R11: sweep every payload length with alternating options
      for (int p = 0; p <= MAXP; p++) begin
         run_frame(p, p[0], p[1], p, 1'b0, 1'b0, 1'b0,
                   (p[0] && p + 14 < MINF) ? "R5" : "R3");
      end

      // R5 boundaries: exactly minimum with pad, one short without pad
      run_frame(MINF - 14, 1'b1, 1'b0, 2, 1'b0, 1'b0, 1'b0, "R5");
      run_frame(MINF - 15, 1'b0, 1'b0, 3, 1'b0, 1'b0, 1'b0, "R5");
      run_frame(0, 1'b1, 1'b1, 4, 1'b0, 1'b0, 1'b0, "R5");

      // R6: one past the limit and the largest header value
      run_bad(MAXP + 1, 3, "R6");
      run_frame(MAXP, 1'b0, 1'b0, 5, 1'b0, 1'b0, 1'b0, "R6");
      run_bad(16'hFFFF, 2, "R6");

      // R9: word write and request in the middle of a frame
      run_frame(30, 1'b0, 1'b1, 6, 1'b0, 1'b1, 1'b0, "R9");
      run_frame(8, 1'b1, 1'b0, 7, 1'b0, 1'b0, 1'b0, "R10");

      // R8: clear pulse coincides with the final handshake
      run_frame(20, 1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0, "R8");

      // R12: one word more than capacity on a full-size frame
      run_frame(MAXP, 1'b1, 1'b1, 3, 1'b0, 1'b0, 1'b1, "R12");

      summary();
   end
endmodule